// File: doc/BRIEF.md
# Hardware Cursor Line Overlay

This block lays a 32 by 32 pixel, two-plane cursor over the pixel stream of a display pipeline. Software places the cursor with an 11-bit horizontal and a 10-bit vertical position, points it at a pattern in video memory and turns it on. Each pattern line has a mask plane and an invert plane. On every display line that the cursor covers, the block reads the two 32-bit plane words for that line through a simple request/response port. The display timing must leave enough horizontal blanking for both reads to finish before the visible line starts.

As 24-bit RGB pixels pass through, the block changes those whose horizontal count falls inside the 32-pixel cursor span. A mask bit of 0 turns the pixel black. An invert bit of 1 then flips all 24 colour bits. Pixels outside the span, and every pixel on lines without the cursor, leave the block unchanged. The output is registered with one cycle of latency.

Under interlaced scan the pattern pointer moves 8 bytes per cursor line. In the odd field the 4-byte offset is added before the fetch, so the odd field reads the lines that the even field skips.

Top module: `cursor_overlay`

## Requirements
- R1: After reset, `pixOut` is 0, `rdReq` is low and the cursor is off, so pixels pass through unchanged once the pipeline runs.
- R2: The horizontal position is {index 1 bits [2:0], index 0} (11 bits). The vertical position is {index 3 bits [1:0], index 2} (10 bits). Both are written through the register port, and the first cursor pixel appears where `hCount` equals the horizontal position.
- R3: Index 4 bit 0 enables the cursor. While it is clear, no memory read is issued and every pixel passes through unchanged.
- R4: The pattern byte address is {index 6 bits [1:0], 2'b11, index 5, 8'h00}. A `frameStart` pulse loads it, and the first cursor line of the frame fetches there.
- R5: Each cursor line issues two one-cycle read requests. The mask word is read at the current address and the invert word at that address plus 128. The memory returns each word with the byte at the lowest address in bits [31:24].
- R6: Word bit 31 applies to the pixel at the horizontal position, and lower bits apply to the pixels that follow in order. Mask bit 0 gives black, and invert bit 1 then flips all 24 bits.
- R7: Pixels outside the 32-pixel horizontal span pass through. Lines outside the 32-line vertical range pass through and issue no read.
- R8: Without interlace, the address of each cursor line is 4 above the address of the cursor line before it.
- R9: With interlace, a field with `oddField`=1 fetches at frame address + 8·n + 4, and a field with `oddField`=0 fetches at frame address + 8·n, where n is the cursor line index within the field.
- R10: `pixOut` shows the result for the `pixIn` and `hCount` sampled one clock earlier.
- R11: Each `frameStart` pulse restarts the pattern address from the current register values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regIdx | input | 3 | Register index |
| regData | input | 8 | Register write data |
| frameStart | input | 1 | Start-of-field pulse |
| lineStart | input | 1 | Start-of-line pulse, given in blanking with `vCount` already set to the coming line |
| interlace | input | 1 | Interlaced scan |
| oddField | input | 1 | Current field is odd |
| hCount | input | 11 | Horizontal pixel count of `pixIn` |
| vCount | input | 10 | Line number of the current or coming line |
| rdReq | output | 1 | Pattern read request, one cycle |
| rdAddr | output | 20 | Pattern byte address |
| rdValid | input | 1 | Read data valid |
| rdData | input | 32 | Read word, lowest byte in bits [31:24] |
| pixIn | input | 24 | Incoming RGB pixel |
| pixOut | output | 24 | Outgoing RGB pixel |

## Verification
The bench builds the block with its default parameters: an 11-bit horizontal position, a 10-bit vertical position, a 32-pixel cursor and 24-bit pixels. At these sizes a full cursor frame, with every line and every pixel from two before the span to two after it, fits easily in the run. The frames exercised include a cursor at position zero, a cursor clipped by the last line and the last pixel count, both interlace field types, and a disabled cursor. The bench computes pattern words from an arithmetic memory image and derives the expected addresses and pixels from the requirements.

// File: rtl/cursor_pkg.sv
package cursor_pkg;

  localparam int ADDR_W = 20;

  typedef enum logic [2:0] {
    REG_XLO  = 3'd0,
    REG_XHI  = 3'd1,
    REG_YLO  = 3'd2,
    REG_YHI  = 3'd3,
    REG_CTRL = 3'd4,
    REG_BASE = 3'd5,
    REG_BANK = 3'd6
  } curReg_t;

  typedef struct packed {
    logic frameLoad;
    logic lineClear;
    logic fetchStart;
    logic selXor;
    logic loadAnd;
    logic loadXor;
    logic lineDone;
  } curStrobe_t;

endpackage

// File: rtl/cursor_ctrl.sv
module cursor_ctrl
  import cursor_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameStart,
  input  logic       lineStart,
  input  logic       curEn,
  input  logic       inRange,
  input  logic       rdValid,
  output logic       rdReq,
  output curStrobe_t st
);

  typedef enum logic [2:0] {
    S_IDLE, S_REQ_AND, S_WAIT_AND, S_REQ_XOR, S_WAIT_XOR
  } state_t;

  state_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    st        = '0;
    rdReq     = 1'b0;
    stateNext = state;
    case (state)
      S_IDLE: begin
        if (lineStart) begin
          st.lineClear = 1'b1;
          if (curEn && inRange) begin
            st.fetchStart = 1'b1;
            stateNext     = S_REQ_AND;
          end
        end
      end
      S_REQ_AND: begin
        rdReq     = 1'b1;
        stateNext = S_WAIT_AND;
      end
      S_WAIT_AND: begin
        if (rdValid) begin
          st.loadAnd = 1'b1;
          stateNext  = S_REQ_XOR;
        end
      end
      S_REQ_XOR: begin
        rdReq     = 1'b1;
        st.selXor = 1'b1;
        stateNext = S_WAIT_XOR;
      end
      S_WAIT_XOR: begin
        st.selXor = 1'b1;
        if (rdValid) begin
          st.loadXor  = 1'b1;
          st.lineDone = 1'b1;
          stateNext   = S_IDLE;
        end
      end
      default: stateNext = S_IDLE;
    endcase
    // a new field aborts any fetch in flight
    if (frameStart) begin
      st.frameLoad = 1'b1;
      st.lineClear = 1'b1;
      stateNext    = S_IDLE;
    end
  end

endmodule

// File: rtl/cursor_dp.sv
module cursor_dp
  import cursor_pkg::*;
#(
  parameter int XW      = 11,
  parameter int YW      = 10,
  parameter int CUR_PIX = 32,
  parameter int PIX_W   = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regIdx,
  input  logic [7:0]        regData,
  input  curStrobe_t        st,
  input  logic              interlace,
  input  logic              oddField,
  input  logic [XW-1:0]     hCount,
  input  logic [YW-1:0]     vCount,
  input  logic [CUR_PIX-1:0] rdData,
  input  logic [PIX_W-1:0]  pixIn,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [PIX_W-1:0]  pixOut,
  output logic              curEn,
  output logic              inRange,
  output logic              lineOn,
  output logic [XW-1:0]     curX
);

  localparam int XHI_W   = XW - 8;
  localparam int YHI_W   = YW - 8;
  localparam int STRIDE  = CUR_PIX / 8;
  localparam int XOR_OFF = CUR_PIX * STRIDE;
  localparam int IW      = $clog2(CUR_PIX);

  logic [7:0]        xLo, yLo, baseReg;
  logic [XHI_W-1:0]  xHi;
  logic [YHI_W-1:0]  yHi;
  logic [1:0]        bankReg;
  logic              enReg;
  logic [YW-1:0]     curY;
  logic [ADDR_W-1:0] patAddr, curAddr, fetchAddr;
  logic [CUR_PIX-1:0] andWord, xorWord;

  // register port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      xLo <= '0; xHi <= '0; yLo <= '0; yHi <= '0;
      enReg <= 1'b0; baseReg <= '0; bankReg <= '0;
    end else if (regWrEn) begin
      case (curReg_t'(regIdx))
        REG_XLO:  xLo     <= regData;
        REG_XHI:  xHi     <= regData[XHI_W-1:0];
        REG_YLO:  yLo     <= regData;
        REG_YHI:  yHi     <= regData[YHI_W-1:0];
        REG_CTRL: enReg   <= regData[0];
        REG_BASE: baseReg <= regData;
        REG_BANK: bankReg <= regData[1:0];
        default: ;
      endcase
    end
  end

  assign curX    = {xHi, xLo};
  assign curY    = {yHi, yLo};
  assign curEn   = enReg;
  assign patAddr = {bankReg, 2'b11, baseReg, 8'h00};

  // vertical window, no wrap-around
  logic [YW:0] dy;
  assign dy      = {1'b0, vCount} - {1'b0, curY};
  assign inRange = !dy[YW] && (dy < (YW+1)'(CUR_PIX));

  // pattern pointer
  logic preStep, postStep;
  assign preStep  = interlace & oddField;
  assign postStep = interlace & ~oddField;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr   <= '0;
      fetchAddr <= '0;
      andWord   <= '0;
      xorWord   <= '0;
      lineOn    <= 1'b0;
    end else begin
      if (st.fetchStart)
        fetchAddr <= curAddr + (preStep ? ADDR_W'(STRIDE) : '0);
      if (st.loadAnd) andWord <= rdData;
      if (st.loadXor) xorWord <= rdData;
      if (st.lineClear) lineOn <= 1'b0;
      if (st.lineDone) begin
        lineOn  <= 1'b1;
        curAddr <= fetchAddr + ADDR_W'(STRIDE) + (postStep ? ADDR_W'(STRIDE) : '0);
      end
      if (st.frameLoad) begin
        curAddr <= patAddr;
        lineOn  <= 1'b0;
      end
    end
  end

  assign rdAddr = fetchAddr + (st.selXor ? ADDR_W'(XOR_OFF) : '0);

  // pixel overlay
  logic [XW:0]   dx;
  logic          inSpan;
  logic [IW-1:0] bitIdx;
  logic [PIX_W-1:0] masked;
  assign dx     = {1'b0, hCount} - {1'b0, curX};
  assign inSpan = lineOn && !dx[XW] && (dx < (XW+1)'(CUR_PIX));
  assign bitIdx = IW'(CUR_PIX - 1) - dx[IW-1:0];
  assign masked = andWord[bitIdx] ? pixIn : '0;

  always_ff @(posedge clk) begin
    if (!rstN)       pixOut <= '0;
    else if (inSpan) pixOut <= masked ^ {PIX_W{xorWord[bitIdx]}};
    else             pixOut <= pixIn;
  end

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_pkg::*;
#(
  parameter int XW      = 11,
  parameter int YW      = 10,
  parameter int CUR_PIX = 32,
  parameter int PIX_W   = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [2:0]         regIdx,
  input  logic [7:0]         regData,
  input  logic               frameStart,
  input  logic               lineStart,
  input  logic               interlace,
  input  logic               oddField,
  input  logic [XW-1:0]      hCount,
  input  logic [YW-1:0]      vCount,
  output logic               rdReq,
  output logic [ADDR_W-1:0]  rdAddr,
  input  logic               rdValid,
  input  logic [CUR_PIX-1:0] rdData,
  input  logic [PIX_W-1:0]   pixIn,
  output logic [PIX_W-1:0]   pixOut
);

  curStrobe_t    st;
  logic          curEn, inRange, lineOn;
  logic [XW-1:0] curX;

  cursor_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .lineStart(lineStart),
    .curEn(curEn), .inRange(inRange), .rdValid(rdValid),
    .rdReq(rdReq), .st(st)
  );

  cursor_dp #(.XW(XW), .YW(YW), .CUR_PIX(CUR_PIX), .PIX_W(PIX_W)) i_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regIdx(regIdx), .regData(regData),
    .st(st), .interlace(interlace), .oddField(oddField),
    .hCount(hCount), .vCount(vCount), .rdData(rdData), .pixIn(pixIn),
    .rdAddr(rdAddr), .pixOut(pixOut), .curEn(curEn), .inRange(inRange),
    .lineOn(lineOn), .curX(curX)
  );

endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk
  import cursor_pkg::*;
#(
  parameter int XW      = 11,
  parameter int CUR_PIX = 32,
  parameter int PIX_W   = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              frameStart,
  input logic              rdReq,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [XW-1:0]     hCount,
  input logic [PIX_W-1:0]  pixIn,
  input logic [PIX_W-1:0]  pixOut,
  input logic              lineOn,
  input logic [XW-1:0]     curX
);

  localparam int XOR_OFF = CUR_PIX * (CUR_PIX / 8);

  logic              phase, validQ, hitQ;
  logic [ADDR_W-1:0] prevAddr;
  logic [PIX_W-1:0]  pixQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= 1'b0; prevAddr <= '0;
      validQ <= 1'b0; hitQ <= 1'b0; pixQ <= '0;
    end else begin
      if (frameStart)  phase <= 1'b0;
      else if (rdReq)  phase <= ~phase;
      if (rdReq) prevAddr <= rdAddr;
      validQ <= 1'b1;
      pixQ   <= pixIn;
      hitQ   <= lineOn && (hCount >= curX) && ((hCount - curX) < XW'(CUR_PIX));
    end
  end

  // R5: each request lasts one cycle
  p_req_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> !rdReq);

  // R5: second read of a line sits one plane above the first
  p_xor_pair_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && phase) |-> (rdAddr == prevAddr + ADDR_W'(XOR_OFF)));

  // R8: pattern reads are word aligned
  p_align_r8: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> (rdAddr[1:0] == 2'b00));

  // R7: pixels outside an active span leave unchanged one cycle later
  p_pass_r7: assert property (@(posedge clk) disable iff (!rstN)
    (validQ && !hitQ) |-> (pixOut == pixQ));

endmodule

bind cursor_overlay cursor_overlay_chk #(.XW(XW), .CUR_PIX(CUR_PIX), .PIX_W(PIX_W)) i_chk (
  .clk(clk), .rstN(rstN), .frameStart(frameStart), .rdReq(rdReq), .rdAddr(rdAddr),
  .hCount(hCount), .pixIn(pixIn), .pixOut(pixOut), .lineOn(lineOn), .curX(curX)
);

// File: tb/test_cursor_overlay.sv
module test_cursor_overlay;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regIdx = '0;
  logic [7:0]  regData = '0;
  logic        frameStart = 1'b0, lineStart = 1'b0;
  logic        interlace = 1'b0, oddField = 1'b0;
  logic [10:0] hCount = '0;
  logic [9:0]  vCount = '0;
  logic        rdReq;
  logic [19:0] rdAddr;
  logic        rdValid = 1'b0;
  logic [31:0] rdData = '0;
  logic [23:0] pixIn = '0;
  logic [23:0] pixOut;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cursor_overlay i_cursor_overlay (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regIdx(regIdx), .regData(regData),
    .frameStart(frameStart), .lineStart(lineStart), .interlace(interlace),
    .oddField(oddField), .hCount(hCount), .vCount(vCount), .rdReq(rdReq),
    .rdAddr(rdAddr), .rdValid(rdValid), .rdData(rdData), .pixIn(pixIn), .pixOut(pixOut)
  );

  function automatic logic [7:0] memByte(logic [19:0] a);
    logic [7:0] p;
    p = a[7:0] * 8'd29;
    return p ^ a[15:8] ^ {a[19:16], a[19:16]};
  endfunction

  function automatic logic [31:0] memWord(logic [19:0] a);
    return {memByte(a), memByte(a + 20'd1), memByte(a + 20'd2), memByte(a + 20'd3)};
  endfunction

  // memory model: answers two cycles after a request
  logic        pend = 1'b0;
  logic [19:0] pendAddr = '0;
  logic [19:0] reqLog [0:7];
  int          reqCnt = 0;

  always @(posedge clk) begin
    pend     <= rdReq;
    pendAddr <= rdAddr;
    rdValid  <= pend;
    rdData   <= memWord(pendAddr);
    if (rdReq) begin
      if (reqCnt < 8) reqLog[reqCnt] = rdAddr;
      reqCnt = reqCnt + 1;
    end
  end

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int idx, int val);
    regWrEn = 1'b1; regIdx = 3'(idx); regData = 8'(val);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic runFrame(int x, int y, int base, int bank, bit en, bit intl, bit odd,
                          int vFirst, int vLast);
    logic [19:0] p, fa;
    logic [31:0] aw, xw;
    int l;
    wr(0, x & 255); wr(1, x >> 8); wr(2, y & 255); wr(3, y >> 8);
    wr(4, en); wr(5, base); wr(6, bank);
    interlace = intl; oddField = odd;
    p = 20'((bank << 18) | (3 << 16) | (base << 8));
    frameStart = 1'b1; @(negedge clk); frameStart = 1'b0;
    l = 0; aw = '0; xw = '0;
    for (int v = vFirst; v <= vLast; v++) begin
      bit has;
      int hs, he;
      has = en && (v >= y) && (v - y < 32);
      vCount = 10'(v); hCount = '0; reqCnt = 0;
      lineStart = 1'b1; @(negedge clk); lineStart = 1'b0;
      repeat (12) @(negedge clk);
      if (has) begin
        fa = p + 20'(intl ? (8 * l + (odd ? 4 : 0)) : 4 * l);
        check(reqCnt == 2, "R5", reqCnt, 2);
        check(reqLog[0] == fa, (l == 0) ? "R4,R11" : (intl ? "R9" : "R8"), reqLog[0], fa);
        check(reqLog[1] == fa + 20'd128, "R5", reqLog[1], fa + 20'd128);
        aw = memWord(fa); xw = memWord(fa + 20'd128);
        l++;
      end else begin
        check(reqCnt == 0, en ? "R7" : "R3", reqCnt, 0);
      end
      hs = (x - 2 < 0) ? 0 : x - 2;
      he = (x + 33 > 2047) ? 2047 : x + 33;
      for (int h = hs; h <= he; h++) begin
        logic [23:0] pin, e;
        int k;
        bit hit;
        pin = {8'(h), 8'(v), 8'(h >> 3) ^ 8'hA5};
        hCount = 11'(h); pixIn = pin;
        @(negedge clk);
        k = h - x;
        hit = has && (k >= 0) && (k < 32);
        e = pin;
        if (hit) begin
          e = aw[31 - k] ? pin : 24'h0;
          if (xw[31 - k]) e = e ^ 24'hFFFFFF;
        end
        // R10: sampled one clock after the pixel was presented
        check(pixOut == e, !hit ? (en ? "R7" : "R3") : ((k == 0) ? "R2" : "R6"),
              pixOut, e);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(pixOut == 24'h0, "R1", pixOut, 0);
    check(rdReq == 1'b0, "R1", rdReq, 0);
    rstN = 1'b1;
    pixIn = 24'h123456; hCount = 11'd5;
    @(negedge clk);
    check(pixOut == 24'h123456, "R1", pixOut, 24'h123456);
    // R10: a new input is not visible until the next edge
    pixIn = 24'hABCDEF;
    check(pixOut == 24'h123456, "R10", pixOut, 24'h123456);
    @(negedge clk);
    check(pixOut == 24'hABCDEF, "R10", pixOut, 24'hABCDEF);

    runFrame(300, 100, 8'h5A, 2, 1, 0, 0, 99, 132);
    runFrame(0, 0, 8'h12, 1, 1, 1, 1, 0, 32);
    runFrame(2027, 1000, 8'hF0, 3, 1, 1, 0, 999, 1023);
    runFrame(500, 200, 8'h33, 0, 0, 0, 0, 199, 202);
    runFrame(300, 100, 8'h5A, 2, 1, 0, 0, 100, 101);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule